// File: doc/BRIEF.md
# One-Shot Countdown Event Timer

This block is an always-on, one-shot event timer that a processor programs through a small register port. A write to the count register loads a down-counter that then steps by one on every input clock, with no prescaler. When it runs out, the counter stops and a sticky pending flag is set. The interrupt line is that flag gated by an interrupt-enable bit. Software acknowledges the event by writing a self-clearing clear bit in the control register.

The control register has a clock-enable bit (bit 0) that guards the other settings. While it is clear, the countdown is cancelled and frozen, and writes to the count register are dropped. The interrupt enable (bit 1) can only be switched on by a write made while the clock enable is already set. Writing zero to the control register stops the timer and masks its interrupt.

Top module: `syst_evt_timer`

## Requirements
- R1: After reset, the control register and the count register both read zero, and `irq` is low.
- R2: The control register is at offset 0x40 and the count register is at offset 0x44. Control bit 0 (clock enable) and bit 1 (interrupt enable) read back as stored. Bit 4 (clear) and all other bits read zero. Any other offset reads zero.
- R3: A write to the count register while the clock enable is set loads the written value at that edge. The count then drops by exactly one on each following clock.
- R4: A write to the count register while the clock enable is clear is ignored, and the count register keeps its previous value.
- R5: A control write stores bit 1 as the interrupt enable only if the clock enable was already set before that write and bit 0 of the written word is one. Any other control write leaves the interrupt enable at zero.
- R6: After a load of N ≥ 1, the pending flag is set at the N-th clock edge after the load edge. At that edge the count reaches zero and then stays at zero (one-shot).
- R7: `irq` equals pending AND interrupt enable. The pending flag stays set while masked, so enabling the interrupt later raises `irq`.
- R8: A control write with bit 4 set clears the pending flag. If a timeout happens at the same edge, the clear wins.
- R9: A control write with bit 0 clear cancels any countdown and freezes the count register at its current value.
- R10: A load of 0 or of 1 sets the pending flag one clock edge after the load.
- R11: The all-ones count (2^CNT_W − 1) loads in full and times out after exactly that many clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| we | input | 1 | Write strobe, one cycle per write |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` (combinational) |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the timer with CNT_W = 8 and the default 32-bit data and 8-bit address. This makes the all-ones timeout only 255 clocks long, so the full-range load and its exact expiry edge can be reached in a short run. With the narrower counter, zero-extension of the count on the 32-bit read path is also checked. A behavioural model is compared against `irq` and `rdata` on every cycle. The scheduled scenarios put a clear on the same edge as a timeout, enable the interrupt while the flag is masked, and stop the timer in the middle of a count.

// File: rtl/syst_evt_timer.sv
module syst_evt_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int CTRL_OFS = 'h40,
  parameter int VAL_OFS  = 'h44
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam int B_EN  = 0;
  localparam int B_IEN = 1;
  localparam int B_CLR = 4;

  logic             clk_en, irq_en, pend, run;
  logic [CNT_W-1:0] cnt;

  wire sel_ctrl = (addr == ADDR_W'(CTRL_OFS));
  wire sel_val  = (addr == ADDR_W'(VAL_OFS));
  wire ctrl_wr  = we && sel_ctrl;
  wire load     = we && sel_val && clk_en;
  wire last     = (cnt <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_en <= 1'b0;
      irq_en <= 1'b0;
      pend   <= 1'b0;
      run    <= 1'b0;
      cnt    <= '0;
    end else begin
      if (run && clk_en) begin
        if (last) begin
          cnt  <= '0;
          run  <= 1'b0;
          pend <= 1'b1;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
      if (ctrl_wr) begin
        clk_en <= wdata[B_EN];
        irq_en <= wdata[B_EN] && clk_en && wdata[B_IEN];
        if (!wdata[B_EN]) run <= 1'b0;
        if (wdata[B_CLR]) pend <= 1'b0;
      end
      if (load) begin
        cnt <= wdata[CNT_W-1:0];
        run <= 1'b1;
      end
    end
  end

  assign irq = pend && irq_en;

  always_comb begin
    rdata = '0;
    if (sel_ctrl) begin
      rdata[B_EN]  = clk_en;
      rdata[B_IEN] = irq_en;
    end else if (sel_val) begin
      rdata = DATA_W'(cnt);
    end
  end

  AST_IEN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) irq_en |-> clk_en); // R5
  AST_IGNORED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel_val && !clk_en) |=> $stable(cnt)); // R4
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clk_en && !last && !load) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[B_CLR]) |=> !pend); // R8
  AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !load) |=> $stable(cnt)); // R9
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt)); // R6
endmodule

// File: tb/syst_evt_timer_tb.sv
module syst_evt_timer_tb_top;
  localparam int CW = 8;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0, rdata;
  logic        irq;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  bit m_en = 0, m_ien = 0, m_pend = 0, m_run = 0;
  longint m_cnt = 0;

  always #10 clk = ~clk;

  syst_evt_timer #(.CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_ien = 0; m_pend = 0; m_run = 0; m_cnt = 0;
    end else begin
      bit o_en;
      o_en = m_en;
      if (m_run && m_en) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_run = 0; m_pend = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (we && addr == 8'h40) begin
        m_en  = wdata[0];
        m_ien = wdata[0] && o_en && wdata[1];
        if (!wdata[0]) m_run = 0;
        if (wdata[4]) m_pend = 0;
      end
      if (we && addr == 8'h44 && o_en) begin
        m_cnt = wdata & MAXC;
        m_run = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      longint e;
      chk("R7 irq", irq, m_pend && m_ien);
      e = (addr == 8'h40) ? {m_ien, m_en} : (addr == 8'h44) ? m_cnt : 0;
      chk((addr == 8'h44) ? "R3 count" : "R2 readback", rdata, e);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 200000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<200000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #1;
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  initial begin
    logic [31:0] v, frozen;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    rd(8'h40, v); chk("R1 ctrl", v, 0);
    rd(8'h44, v); chk("R1 count", v, 0);
    chk("R1 irq", irq, 0);

    wr(8'h44, 32'd10); rd(8'h44, v); chk("R4 load ignored", v, 0);
    wr(8'h40, 32'h13); rd(8'h40, v); chk("R5 ien blocked", v, 1);
    wr(8'h40, 32'hFFFF_FF03); rd(8'h40, v); chk("R2 bits", v, 3);
    rd(8'h48, v); chk("R2 unmapped", v, 0);

    wr(8'h44, 32'd5); rd(8'h44, v); chk("R3 loaded", v, 5);
    idle(1); rd(8'h44, v); chk("R3 step", v, 4);
    idle(3); chk("R6 not yet", irq, 0);
    idle(1); chk("R6 timeout", irq, 1);
    idle(10); rd(8'h44, v); chk("R6 stays zero", v, 0);

    wr(8'h40, 32'h11); chk("R8 cleared", irq, 0);
    rd(8'h40, v); chk("R8 ctrl", v, 1);

    wr(8'h44, 32'd3); idle(5); chk("R7 masked", irq, 0);
    wr(8'h40, 32'h3); chk("R7 late enable", irq, 1);
    wr(8'h40, 32'h13); chk("R8 ack", irq, 0);
    rd(8'h40, v); chk("R2 clr reads 0", v, 3);

    wr(8'h44, 32'd4); idle(3); wr(8'h40, 32'h13);
    chk("R8 clear wins", irq, 0);
    idle(3); chk("R8 stays clear", irq, 0);

    wr(8'h44, 32'd50); idle(5); wr(8'h40, 32'h0);
    rd(8'h44, frozen); idle(10); rd(8'h44, v);
    chk("R9 frozen", v, frozen);
    chk("R9 value", frozen, 44);
    rd(8'h40, v); chk("R9 ctrl off", v, 0);

    wr(8'h40, 32'h1); wr(8'h40, 32'h3);
    wr(8'h44, 32'd0); idle(1); chk("R10 zero", irq, 1);
    wr(8'h40, 32'h13); wr(8'h40, 32'h3);
    wr(8'h44, 32'd1); idle(1); chk("R10 one", irq, 1);
    wr(8'h40, 32'h13); wr(8'h40, 32'h3);

    wr(8'h44, 32'hFFFF_FFFF); rd(8'h44, v); chk("R11 full load", v, MAXC);
    idle(MAXC - 1); chk("R11 before", irq, 0);
    idle(1); chk("R11 expiry", irq, 1);

    idle(2);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule